// File: doc/BRIEF.md
# Addressed Single-Channel Output Latch

This block holds the on/off state of eight output channels and changes one channel per write. A host drives a three-bit channel number, a level bit and an active-low select line. The channel number is taken when the select line goes low. The level bit is taken when the select line returns high, and at that same moment the chosen channel is switched on or off. Every other channel keeps its state, because the register is updated by a read-modify-write of a single bit. Two active-low override lines switch all channels on or all channels off at once; the all-off line wins when both are low.

All pins from the host are treated as asynchronous. They pass through a two-stage synchronizer on the system clock, and the select-line edges are detected on the synchronized copy. The channel number and the level bit travel in the same pipeline, so they stay aligned with the select line. On each rising select edge a one-cycle write strobe is issued, which a power-save sequencer downstream can use to restart its hold timer. The 8-bit state vector and the strobe are both registered outputs.

Top module: `chlatch_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ch_on` is all zeros and `wr_stb` is low.
- R2: The channel number on `addr` is sampled at the falling edge of `cs_n`. Value k (binary, 0 to 7) selects channel k+1, which is bit k of `ch_on`.
- R3: At the rising edge of `cs_n`, the selected bit becomes the value of `lvl` (1 = on, 0 = off). All other bits keep their value.
- R4: A change on `addr` after `cs_n` has fallen has no effect on which bit the next rising edge updates.
- R5: The value of `lvl` present at the rising edge of `cs_n` is the one written, even if `lvl` held another value earlier in the same low period.
- R6: While `cs_n` stays high, activity on `addr` and `lvl` leaves `ch_on` unchanged and produces no strobe.
- R7: While `all_on_n` is low and `all_off_n` is high, every bit of `ch_on` is 1.
- R8: While `all_off_n` is low, every bit of `ch_on` is 0, whatever `all_on_n` and `cs_n` do.
- R9: Each rising edge of `cs_n` produces exactly one `wr_stb` pulse, one cycle wide. The pulse and the `ch_on` update appear on the third rising clock edge after the `cs_n` rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; falling edge takes the address, rising edge commits the write |
| addr | input | 3 | Channel number, 0 selects channel 1 |
| lvl | input | 1 | Value written to the selected channel |
| all_on_n | input | 1 | Active-low: switch every channel on |
| all_off_n | input | 1 | Active-low: switch every channel off; overrides all other inputs |
| ch_on | output | 8 | Channel state, bit k is channel k+1 |
| wr_stb | output | 1 | One-cycle pulse per committed write |

## Verification
The hardest case to reach is the one where the channel number moves during the low phase of the select line. To cover it, the bench holds `cs_n` low long enough for the falling edge to pass the synchronizer, then changes `addr` to a different channel, and only then raises `cs_n`. It then checks that only the bit from the earlier address changed. The same split-phase stimulus flips `lvl` partway through the low phase, to show that the value present at the rising edge is the one written. A cycle-exact probe around one write confirms the three-edge latency and the single-cycle strobe.

// File: rtl/chlatch_pkg.sv
package chlatch_pkg;
  parameter int unsigned CHL_SYNC_DEPTH = 2;

  typedef struct packed {
    logic cs_n;
    logic on_n;
    logic off_n;
    logic lvl;
  } chl_ctrl_t;

  localparam chl_ctrl_t CHL_CTRL_IDLE = '{cs_n: 1'b1, on_n: 1'b1, off_n: 1'b1, lvl: 1'b0};
endpackage

// File: rtl/chlatch_sync.sv
module chlatch_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/chlatch_edge.sv
module chlatch_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sel_n;
  end

  assign fall = prev_q & ~sel_n;
  assign rise = ~prev_q & sel_n;
endmodule

// File: rtl/chlatch_reg.sv
module chlatch_reg #(
  parameter int unsigned NCH = 8,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fall,
  input  logic           rise,
  input  logic [AW-1:0]  addr_s,
  input  logic           lvl_s,
  input  logic           on_n_s,
  input  logic           off_n_s,
  output logic [NCH-1:0] ctl_q,
  output logic           stb_q
);
  logic [AW-1:0]  addr_q;
  logic [NCH-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (fall) addr_q <= addr_s;
  end

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= rise;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    assign sel[i] = (addr_q == AW'(i));

    always_ff @(posedge clk) begin
      if (rst)                  ctl_q[i] <= 1'b0;
      else if (!off_n_s)        ctl_q[i] <= 1'b0;
      else if (!on_n_s)         ctl_q[i] <= 1'b1;
      else if (rise && sel[i])  ctl_q[i] <= lvl_s;
    end
  end

  // R8
  off_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !off_n_s |=> (ctl_q == '0));

  // R7
  all_on_chk: assert property (@(posedge clk) disable iff (rst)
    (off_n_s && !on_n_s) |=> (&ctl_q));

  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (off_n_s && on_n_s) |=> ($countones(ctl_q ^ $past(ctl_q)) <= 1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (off_n_s && on_n_s && !rise) |=> $stable(ctl_q));
endmodule

// File: rtl/chlatch_ctrl.sv
module chlatch_ctrl
  import chlatch_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CW = $bits(chl_ctrl_t),
  localparam int unsigned SW = CW + AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic [AW-1:0]  addr,
  input  logic           lvl,
  input  logic           all_on_n,
  input  logic           all_off_n,
  output logic [NCH-1:0] ch_on,
  output logic           wr_stb
);
  chl_ctrl_t     ctrl_raw, ctrl_s;
  logic [AW-1:0] addr_s;
  logic [SW-1:0] sync_q;
  logic          fall, rise;

  assign ctrl_raw = '{cs_n: cs_n, on_n: all_on_n, off_n: all_off_n, lvl: lvl};

  chlatch_sync #(
    .W(SW), .STAGES(CHL_SYNC_DEPTH),
    .RST_VAL({CHL_CTRL_IDLE, {AW{1'b0}}})
  ) u_sync (
    .clk(clk), .rst(rst), .d({ctrl_raw, addr}), .q(sync_q)
  );

  assign ctrl_s = chl_ctrl_t'(sync_q[SW-1:AW]);
  assign addr_s = sync_q[AW-1:0];

  chlatch_edge u_edge (
    .clk(clk), .rst(rst), .sel_n(ctrl_s.cs_n), .fall(fall), .rise(rise)
  );

  chlatch_reg #(.NCH(NCH)) u_reg (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .addr_s(addr_s), .lvl_s(ctrl_s.lvl),
    .on_n_s(ctrl_s.on_n), .off_n_s(ctrl_s.off_n),
    .ctl_q(ch_on), .stb_q(wr_stb)
  );

  // R9
  stb_width_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
endmodule

// File: tb/chlatch_ctrl_bench.sv
module chlatch_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic [2:0] addr = '0;
  logic       lvl = 1'b0;
  logic       all_on_n = 1'b1;
  logic       all_off_n = 1'b1;
  logic [7:0] ch_on;
  logic       wr_stb;

  int n_run = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  logic [7:0] exp_on = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chlatch_ctrl u_chlatch_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .lvl(lvl),
    .all_on_n(all_on_n), .all_off_n(all_off_n), .ch_on(ch_on), .wr_stb(wr_stb)
  );

  always @(negedge clk) if (!rst && wr_stb) stb_cnt++;

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [2:0] a, logic l);
    @(negedge clk); addr = a; cs_n = 1'b0;
    idle(4);
    lvl = l; cs_n = 1'b1;
    idle(5);
    exp_on[a] = l;
  endtask

  task automatic t_reset();
    idle(1);
    check("R1 ch_on in reset", ch_on, 0);
    check("R1 wr_stb in reset", wr_stb, 0);
    @(negedge clk); rst = 1'b0;
    idle(1);
    check("R1 ch_on after reset", ch_on, 0);
    check("R1 wr_stb after reset", wr_stb, 0);
  endtask

  task automatic t_addr_map();
    for (int k = 0; k < 8; k++) begin
      do_write(3'(k), 1'b1);
      check($sformatf("R2 channel %0d on", k + 1), ch_on, exp_on);
    end
    do_write(3'd3, 1'b0);
    do_write(3'd6, 1'b0);
    check("R3 clear ch4 and ch7, others kept", ch_on, 8'hB7);
    check("R3 model agrees", exp_on, 8'hB7);
  endtask

  task automatic t_addr_late();
    @(negedge clk); addr = 3'd3; cs_n = 1'b0;
    idle(4);
    addr = 3'd0;
    idle(3);
    lvl = 1'b1; cs_n = 1'b1;
    idle(5);
    check("R4 late address ignored", ch_on, 8'hBF);
    exp_on = 8'hBF;
  endtask

  task automatic t_lvl_late();
    @(negedge clk); addr = 3'd7; lvl = 1'b1; cs_n = 1'b0;
    idle(4);
    lvl = 1'b0;
    idle(2);
    cs_n = 1'b1;
    idle(5);
    exp_on[7] = 1'b0;
    check("R5 level at rising edge used", ch_on, exp_on);
  endtask

  task automatic t_cs_high();
    int s0 = stb_cnt;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); addr = 3'(i); lvl = ~lvl;
    end
    idle(4);
    check("R6 outputs unchanged with select high", ch_on, exp_on);
    check("R6 no strobe with select high", stb_cnt - s0, 0);
  endtask

  task automatic t_latency();
    int s0;
    do_write(3'd0, 1'b0);
    s0 = stb_cnt;
    @(negedge clk); addr = 3'd2; cs_n = 1'b0;
    idle(4);
    lvl = 1'b0; cs_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 no update after two edges", ch_on, exp_on);
    check("R9 no strobe after two edges", wr_stb, 0);
    @(negedge clk);
    exp_on[2] = 1'b0;
    check("R9 update on third edge", ch_on, exp_on);
    check("R9 strobe on third edge", wr_stb, 1);
    @(negedge clk);
    check("R9 strobe one cycle", wr_stb, 0);
    idle(3);
    check("R9 one strobe per write", stb_cnt - s0, 1);
  endtask

  task automatic t_force();
    @(negedge clk); all_on_n = 1'b0;
    idle(4);
    check("R7 all on", ch_on, 8'hFF);
    all_off_n = 1'b0;
    idle(4);
    check("R8 off wins over on", ch_on, 8'h00);
    cs_n = 1'b0; addr = 3'd1; lvl = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(5);
    check("R8 write blocked while off held", ch_on, 8'h00);
    all_off_n = 1'b1; all_on_n = 1'b1;
    idle(4);
    check("R8 stays off after release", ch_on, 8'h00);
    exp_on = '0;
  endtask

  initial begin
    t_reset();
    t_addr_map();
    t_addr_late();
    t_lvl_late();
    t_cs_high();
    t_latency();
    t_force();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule